// File: doc/BRIEF.md
# I2C SCL Period Generator

This block sets the SCL timing for an I2C master. One configuration byte carries two fields. A small predivider turns the system clock into an internal tick. A period field then sets how many ticks each half of the SCL cycle lasts, on top of a fixed base count. The generator drives SCL low for the low half and then releases it. It starts counting the high half only when the synchronised bus line actually reads high. Rise time and any slave that stretches the clock therefore add to the period as a delay term, with no extra logic.

The byte engine places start, data and stop events using four one-cycle strobes: the first cycle of the low half, its midpoint, the first counted cycle of the high half, and its midpoint. When the enable input is clear, the generator idles with SCL released. A new configuration byte is taken only at the start of a low half, so a period that is already running keeps its shape.

Top module: `scl_timer`

## Requirements
- R1: In `div_cfg`, bits 7:2 hold the period field N (0..63) and bits 1:0 hold the predivider C (0..3).
- R2: One internal tick lasts 1+C clock cycles, and every phase length is a whole number of ticks.
- R3: The low half drives `scl_out` to 0 for exactly (10+4N)·(1+C) cycles. The count runs from the `stb_fall` cycle to the cycle before SCL is released.
- R4: After release, the high count starts only once `scl_in` has been seen high through a two-stage synchroniser. With a free line, `stb_rise` comes 3 cycles after release. Each extra cycle the line is held low adds one cycle to that delay.
- R5: The next `stb_fall` comes (10+4N)·(1+C) cycles after `stb_rise`. One period is therefore 20+8N ticks plus the line delay.
- R6: `stb_low_mid` comes (5+2N)·(1+C) cycles after `stb_fall`, and `stb_high_mid` comes the same distance after `stb_rise`.
- R7: Each strobe is one cycle wide, and at most one strobe is high in any cycle.
- R8: If `en` is low at a clock edge, the next cycle has `scl_out`=1 and no strobes. If `en` is high at an edge while idle, the next cycle shows `stb_fall`.
- R9: A change to `div_cfg` during a period does not affect that period. It takes effect from the next `stb_fall`.
- R10: After reset, `scl_out` is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Master enable; low keeps SCL released |
| div_cfg | input | 8 | Period field [7:2], predivider [1:0] |
| scl_in | input | 1 | Sampled level of the SCL bus line |
| scl_out | output | 1 | 0 drives SCL low, 1 releases it |
| stb_fall | output | 1 | First cycle of the low half |
| stb_low_mid | output | 1 | Midpoint of the low half |
| stb_rise | output | 1 | First counted cycle of the high half |
| stb_high_mid | output | 1 | Midpoint of the high half |

## Verification
Every result is a cycle distance from an earlier event. The low-mid strobe is due (5+2N)(1+C) cycles after the fall strobe, and release is due (10+4N)(1+C) cycles after it. The rise strobe is due 3+S cycles after release, where S is the time the bench holds the line low. The next fall is due one low-half length after the rise. The bench counts rising edges and reads every output at the falling edge. It takes the difference of two such counts, so each register in the path is counted once, in the cycle where its output becomes visible. The enable and reset results are checked in the first cycle after the edge that acts on them.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  localparam int SG_PER_W = 6;
  localparam int SG_PRE_W = 2;
  localparam int SG_CFG_W = SG_PER_W + SG_PRE_W;
  localparam int SG_BASE  = 20;
  localparam int SG_STEP  = 8;
  localparam int SG_PH_W  =
    $clog2(SG_BASE / 2 + (SG_STEP / 2) * ((1 << SG_PER_W) - 1) + 1);

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_LOW  = 2'd1,
    SG_WAIT = 2'd2,
    SG_HIGH = 2'd3
  } sg_state_t;

  // ticks in one half of the SCL period
  function automatic logic [SG_PH_W-1:0] half_ticks(input logic [SG_PER_W-1:0] per);
    return SG_PH_W'(SG_BASE / 2) + SG_PH_W'(SG_STEP / 2) * SG_PH_W'(per);
  endfunction

  // ticks from the start of a half to its midpoint strobe
  function automatic logic [SG_PH_W-1:0] quarter_ticks(input logic [SG_PER_W-1:0] per);
    return half_ticks(per) >> 1;
  endfunction
endpackage

// File: rtl/scl_timer_presc.sv
module scl_timer_presc
  import scl_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [SG_PRE_W-1:0] div,
  output logic [SG_PRE_W-1:0] cnt,
  output logic                tick
);
  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr||tick) cnt <= '0;
    else                cnt <= cnt + SG_PRE_W'(1);
  end
endmodule

// File: rtl/scl_timer_sync.sv
module scl_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/scl_timer_fsm.sv
module scl_timer_fsm
  import scl_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SG_CFG_W-1:0] cfg,
  input  logic                tick,
  input  logic                line_hi,
  output sg_state_t           state,
  output logic [SG_PH_W-1:0]  ph,
  output logic [SG_PER_W-1:0] per_q,
  output logic [SG_PRE_W-1:0] pre_q,
  output logic                restart
);
  sg_state_t          nxt;
  logic               load;
  logic [SG_PH_W-1:0] last;

  assign last = half_ticks(per_q) - SG_PH_W'(1);

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    load    = 1'b0;
    if (!en) begin
      nxt     = SG_IDLE;
      restart = 1'b1;
    end else begin
      unique case (state)
        SG_IDLE: begin
          nxt = SG_LOW; restart = 1'b1; load = 1'b1;
        end
        SG_LOW: if (tick && ph == last) begin
          nxt = SG_WAIT; restart = 1'b1;
        end
        SG_WAIT: begin
          restart = 1'b1;
          if (line_hi) nxt = SG_HIGH;
        end
        SG_HIGH: if (tick && ph == last) begin
          nxt = SG_LOW; restart = 1'b1; load = 1'b1;
        end
        default: nxt = SG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SG_IDLE;
      ph    <= '0;
      per_q <= '0;
      pre_q <= '0;
    end else begin
      state <= nxt;
      if (restart)   ph <= '0;
      else if (tick) ph <= ph + SG_PH_W'(1);
      if (load) begin
        per_q <= cfg[SG_CFG_W-1:SG_PRE_W];
        pre_q <= cfg[SG_PRE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import scl_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SG_CFG_W-1:0] div_cfg,
  input  logic                scl_in,
  output logic                scl_out,
  output logic                stb_fall,
  output logic                stb_low_mid,
  output logic                stb_rise,
  output logic                stb_high_mid
);
  sg_state_t           state;
  logic [SG_PH_W-1:0]  ph;
  logic [SG_PER_W-1:0] per_q;
  logic [SG_PRE_W-1:0] pre_q;
  logic [SG_PRE_W-1:0] pre_cnt;
  logic                restart, tick, line_hi;
  logic                half_start, at_mid;

  scl_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(line_hi)
  );

  scl_timer_presc u_presc (
    .clk(clk), .rst_n(rst_n), .clr(restart), .div(pre_q),
    .cnt(pre_cnt), .tick(tick)
  );

  scl_timer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg(div_cfg), .tick(tick),
    .line_hi(line_hi), .state(state), .ph(ph), .per_q(per_q),
    .pre_q(pre_q), .restart(restart)
  );

  // named events for the strobes and the checker
  assign half_start = (pre_cnt == '0) && (ph == '0);
  assign at_mid     = (pre_cnt == '0) && (ph == quarter_ticks(per_q));

  assign scl_out      = (state != SG_LOW);
  assign stb_fall     = (state == SG_LOW)  && half_start;
  assign stb_low_mid  = (state == SG_LOW)  && at_mid;
  assign stb_rise     = (state == SG_HIGH) && half_start;
  assign stb_high_mid = (state == SG_HIGH) && at_mid;
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk
  import scl_timer_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                scl_in,
  input logic                scl_out,
  input logic                stb_fall,
  input logic                stb_low_mid,
  input logic                stb_rise,
  input logic                stb_high_mid,
  input logic [SG_PER_W-1:0] per_q,
  input logic [SG_PRE_W-1:0] pre_q
);
  logic [15:0] low_cnt;
  logic [15:0] low_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (scl_out) low_cnt <= '0;
    else              low_cnt <= low_cnt + 16'd1;
  end

  assign low_exp = 16'(half_ticks(per_q)) * (16'(pre_q) + 16'd1);

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_out && !stb_fall && !stb_low_mid && !stb_rise && !stb_high_mid)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_fall, stb_low_mid, stb_rise, stb_high_mid})); // R7
  AST_FALL_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |-> !scl_out); // R3
  AST_RISE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |-> $past(scl_in, 3)); // R4
  AST_CFG_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_out && $past(!scl_out)) |-> $stable({per_q, pre_q})); // R9
  AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_out) && $past(en)) |-> (low_cnt == low_exp)); // R3
endmodule

bind scl_timer scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .scl_out(scl_out),
  .stb_fall(stb_fall), .stb_low_mid(stb_low_mid), .stb_rise(stb_rise),
  .stb_high_mid(stb_high_mid), .per_q(per_q), .pre_q(pre_q)
);

// File: tb/scl_timer_bench.sv
module scl_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div_cfg = 8'h00;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_out, stb_fall, stb_low_mid, stb_rise, stb_high_mid;
  int         cyc = 0;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = scl_out & ~hold;

  scl_timer u_scl_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .div_cfg(div_cfg), .scl_in(scl_in),
    .scl_out(scl_out), .stb_fall(stb_fall), .stb_low_mid(stb_low_mid),
    .stb_rise(stb_rise), .stb_high_mid(stb_high_mid)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // which: 0 fall, 1 low mid, 2 release, 3 rise, 4 high mid
  task automatic wait_sig(input int which, output int t);
    bit seen = 0;
    t = -1;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      case (which)
        0: seen = stb_fall;
        1: seen = stb_low_mid;
        2: seen = scl_out;
        3: seen = stb_rise;
        default: seen = stb_high_mid;
      endcase
      if (seen) t = cyc;
    end
    if (!seen) chk(0, 1, $sformatf("R7 event %0d never seen", which));
  endtask

  function automatic int half_len(input logic [7:0] c);
    return (10 + 4 * int'(c[7:2])) * (1 + int'(c[1:0]));
  endfunction

  // R1 R2 R3 R4 R5 R6: one period measured at a given setting and stretch
  task automatic measure(input logic [7:0] c, input int s);
    int t0, t1, t2, t3, t4, t5;
    int hl = half_len(c);
    @(negedge clk); en = 1'b0;
    @(negedge clk); div_cfg = c; en = 1'b1;
    wait_sig(0, t0);
    wait_sig(1, t1);
    wait_sig(2, t2);
    if (s > 0) begin
      hold = 1'b1;
      repeat (s) @(negedge clk);
      hold = 1'b0;
    end
    wait_sig(3, t3);
    wait_sig(4, t4);
    wait_sig(0, t5);
    chk(t1 - t0, hl / 2, $sformatf("R6 low mid cfg=%02h", c));
    chk(t2 - t0, hl,     $sformatf("R3 R1 R2 low half cfg=%02h", c));
    chk(t3 - t2, 3 + s,  $sformatf("R4 release to rise cfg=%02h", c));
    chk(t4 - t3, hl / 2, $sformatf("R6 high mid cfg=%02h", c));
    chk(t5 - t3, hl,     $sformatf("R5 high half cfg=%02h", c));
  endtask

  // R9: setting changed after a fall only shapes the following period
  task automatic cfg_change(input logic [7:0] a, input logic [7:0] b);
    int t0, t1, t2, t3, t4, t5;
    @(negedge clk); en = 1'b0;
    @(negedge clk); div_cfg = a; en = 1'b1;
    wait_sig(0, t0);
    div_cfg = b;
    wait_sig(2, t1);
    wait_sig(3, t2);
    wait_sig(0, t3);
    wait_sig(1, t4);
    wait_sig(2, t5);
    chk(t1 - t0, half_len(a), "R9 old low half kept");
    chk(t3 - t2, half_len(a), "R9 old high half kept");
    chk(t4 - t3, half_len(b) / 2, "R9 new low mid");
    chk(t5 - t3, half_len(b), "R9 new low half");
  endtask

  // R8: enable clear releases SCL at once; set again gives an immediate fall
  task automatic enable_test();
    int t0, n = 0;
    @(negedge clk); en = 1'b0;
    @(negedge clk); div_cfg = 8'h10; en = 1'b1;
    wait_sig(1, t0);
    chk(int'(scl_out), 0, "R8 low before disable");
    en = 1'b0;
    @(negedge clk);
    chk(int'(scl_out), 1, "R8 released after disable");
    for (int i = 0; i < 40; i++) begin
      if (stb_fall | stb_low_mid | stb_rise | stb_high_mid | !scl_out) n++;
      @(negedge clk);
    end
    chk(n, 0, "R8 idle cycles with activity");
    en = 1'b1;
    @(negedge clk);
    chk(int'(stb_fall), 1, "R8 fall right after enable");
    chk(int'(scl_out), 0, "R8 SCL low after enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(scl_out), 1, "R10 reset SCL released");
    chk(int'({stb_fall, stb_low_mid, stb_rise, stb_high_mid}), 0, "R10 reset strobes");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(scl_out), 1, "R10 idle after reset");
    measure(8'h00, 0);
    measure(8'h06, 0);
    measure(8'h04, 0);
    measure(8'h0B, 7);
    measure(8'hFF, 0);
    cfg_change(8'h00, 8'h09);
    enable_test();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule